// File: doc/BRIEF.md
# Command Mailbox Buffer with Checksum

This block is the command side of a host mailbox. A host fills it one byte at a time through a byte-wide write port. In a complete device that port sits behind a serial front-end. The host opens each command with a strobe that moves the write pointer back to the base. It then writes the block, which may arrive as several bursts with idle gaps between them. The first byte stored is a count giving the whole block length. That length includes the count byte itself and the two checksum bytes at the end.

When the last checksum byte arrives, the block compares the checksum with a CRC-16 it has computed over the preceding bytes. On a match it pulses a release strobe for a downstream executor. The executor then reads the stored bytes through a combinational read port. On a mismatch, an invalid count, a stray non-filler byte after the block, or more than the buffer can hold, the block raises a sticky error flag. While any error flag is set, further writes are ignored. Only the next pointer-reset strobe clears the error flags and lets the host retry.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, `cmd_valid`, `crc_err`, `overflow_err` and `format_err` are all low.
- R2: A `ptr_rst` strobe clears all error flags and returns the pointer to the base, so the next accepted byte is taken as the count byte.
- R3: Idle cycles between byte writes of one block do not change the outcome; the pointer only moves on accepted writes.
- R4: The count byte sets the block length N. After the edge that accepts byte N-1 (0-based), `cmd_valid` is high for exactly one cycle and `cmd_len` equals N.
- R5: The checksum is CRC-16 with polynomial 0x8005, initial value 0x0000, no reflection and no final XOR. It covers bytes 0 to N-3, and bytes N-2 and N-1 carry it most significant byte first. A match releases the command.
- R6: A checksum mismatch sets `crc_err` with no release. Later writes are ignored and the flag stays set until `ptr_rst`. A block written again after `ptr_rst` is accepted.
- R7: Bytes of value 0xFF written after the checksum raise no flag and leave the stored command and `cmd_len` unchanged.
- R8: A byte other than 0xFF written after the checksum sets `format_err`.
- R9: A count byte below 3 or above 64 sets `format_err`, and no release follows for that block.
- R10: A write accepted while 64 bytes have already been taken sets `overflow_err`.
- R11: `rd_data` shows, in the same cycle, the stored byte at index `rd_addr` of the current block.
- R12: When `ptr_rst` and `wr_en` are high in the same cycle, the pointer reset wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_rst | input | 1 | Pointer-reset strobe that also clears the error flags |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 6 | Executor read index |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| cmd_valid | output | 1 | One-cycle release pulse |
| cmd_len | output | 7 | Length of the stored block |
| crc_err | output | 1 | Sticky checksum mismatch |
| overflow_err | output | 1 | Sticky buffer overflow |
| format_err | output | 1 | Sticky count or trailing-byte error |

## Verification
Every result is registered once, so all results become visible right after the edge that accepts the deciding byte. The release pulse follows the edge that takes the final checksum byte. The error flags follow the edge that takes the offending byte. The bench drives each write for one edge and samples two time units after that edge. It checks `cmd_valid` there and again one cycle later to confirm that the pulse is a single cycle. The read port is combinational, so stored bytes are compared as soon as the block is released.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int          MBX_DEPTH = 64;
  localparam int          BYTE_W    = 8;
  localparam int          CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h8005;
  localparam int          MIN_LEN   = 3;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;
endpackage

// File: rtl/mbx_crc_step.sv
module mbx_crc_step #(
  parameter int               CRC_W  = mbx_pkg::CRC_W,
  parameter int               BYTE_W = mbx_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY   = mbx_pkg::CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_in ^ {data_in, {(CRC_W-BYTE_W){1'b0}}};
    for (int b = 0; b < BYTE_W; b++) begin
      if (c[CRC_W-1]) c = (c << 1) ^ POLY;
      else            c = c << 1;
    end
    crc_out = c;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DEPTH  = mbx_pkg::MBX_DEPTH,
  parameter int BYTE_W = mbx_pkg::BYTE_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int DEPTH  = mbx_pkg::MBX_DEPTH,
  parameter int BYTE_W = mbx_pkg::BYTE_W,
  parameter int CRC_W  = mbx_pkg::CRC_W,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CRC_W-1:0]  crc_next,
  output logic [CRC_W-1:0]  crc_seed,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cmd_valid,
  output logic [PTR_W-1:0]  cmd_len,
  output logic              crc_err,
  output logic              overflow_err,
  output logic              format_err
);
  localparam logic [PTR_W-1:0]  FULL_PTR = PTR_W'(DEPTH);
  localparam logic [BYTE_W-1:0] MAX_CNT  = BYTE_W'(DEPTH);
  localparam logic [BYTE_W-1:0] MIN_CNT  = BYTE_W'(mbx_pkg::MIN_LEN);

  logic [PTR_W-1:0]  ptr_q,  ptr_d;
  logic [BYTE_W-1:0] cnt_q,  cnt_d;
  logic [CRC_W-1:0]  crc_q,  crc_d;
  logic [BYTE_W-1:0] hi_q,   hi_d;
  logic              cerr_q, cerr_d, ovf_q, ovf_d, fmt_q, fmt_d;
  logic              valid_q, valid_d;
  logic              lock, take, upd;
  logic [BYTE_W-1:0] idx;

  assign lock     = cerr_q | ovf_q | fmt_q;
  assign take     = wr_en & ~lock & ~ptr_rst;
  assign upd      = ptr_rst | take;
  assign idx      = BYTE_W'(ptr_q);
  assign crc_seed = (ptr_q == '0) ? '0 : crc_q;
  assign mem_addr = ptr_q[ADDR_W-1:0];

  always_comb begin
    ptr_d = ptr_q; cnt_d = cnt_q; crc_d = crc_q; hi_d = hi_q;
    cerr_d = cerr_q; ovf_d = ovf_q; fmt_d = fmt_q;
    valid_d = 1'b0; mem_we = 1'b0;
    if (ptr_rst) begin
      ptr_d = '0; cnt_d = '0; crc_d = '0; hi_d = '0;
      cerr_d = 1'b0; ovf_d = 1'b0; fmt_d = 1'b0;
    end else if (take) begin
      if (ptr_q == FULL_PTR) begin
        ovf_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
        if (ptr_q == '0) begin
          mem_we = 1'b1;
          cnt_d  = wr_data;
          crc_d  = crc_next;
          if (wr_data < MIN_CNT || wr_data > MAX_CNT) fmt_d = 1'b1;
        end else if (idx < cnt_q) begin
          mem_we = 1'b1;
          if (idx < cnt_q - 8'd2)       crc_d = crc_next;
          else if (idx == cnt_q - 8'd2) hi_d  = wr_data;
          else if ({hi_q, wr_data} == crc_q) valid_d = 1'b1;
          else cerr_d = 1'b1;
        end else if (wr_data != mbx_pkg::FILL_BYTE) begin
          fmt_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; cnt_q <= '0; crc_q <= '0; hi_q <= '0;
      cerr_q <= 1'b0; ovf_q <= 1'b0; fmt_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (upd) begin
        ptr_q <= ptr_d; cnt_q <= cnt_d; crc_q <= crc_d; hi_q <= hi_d;
        cerr_q <= cerr_d; ovf_q <= ovf_d; fmt_q <= fmt_d;
      end
    end
  end

  assign cmd_valid    = valid_q;
  assign cmd_len      = cnt_q[PTR_W-1:0];
  assign crc_err      = cerr_q;
  assign overflow_err = ovf_q;
  assign format_err   = fmt_q;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int DEPTH  = mbx_pkg::MBX_DEPTH,
  parameter int BYTE_W = mbx_pkg::BYTE_W,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [PTR_W-1:0]  cmd_len,
  output logic              crc_err,
  output logic              overflow_err,
  output logic              format_err
);
  localparam int CRC_W = mbx_pkg::CRC_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [CRC_W-1:0]  crc_seed, crc_next;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mbx_crc_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_crc (
    .crc_in(crc_seed), .data_in(wr_data), .crc_out(crc_next)
  );

  mbx_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  mbx_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .CRC_W(CRC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .ptr_rst(ptr_rst), .wr_en(wr_en),
    .wr_data(wr_data), .crc_next(crc_next), .crc_seed(crc_seed),
    .mem_we(mem_we), .mem_addr(mem_addr), .cmd_valid(cmd_valid),
    .cmd_len(cmd_len), .crc_err(crc_err), .overflow_err(overflow_err),
    .format_err(format_err)
  );
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int DEPTH = mbx_pkg::MBX_DEPTH,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ptr_rst,
  input logic             wr_en,
  input logic             cmd_valid,
  input logic [PTR_W-1:0] cmd_len,
  input logic             crc_err,
  input logic             overflow_err,
  input logic             format_err
);
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R4
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len >= PTR_W'(mbx_pkg::MIN_LEN) && cmd_len <= PTR_W'(DEPTH)));
  // R6
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !ptr_rst) |=> crc_err);
  // R6
  no_release_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && crc_err));
  // R2
  ptr_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> !(crc_err || overflow_err || format_err || cmd_valid));
  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_err) |-> $past(wr_en));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst), .wr_en(wr_en),
  .cmd_valid(cmd_valid), .cmd_len(cmd_len), .crc_err(crc_err),
  .overflow_err(overflow_err), .format_err(format_err)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;
  logic       clk = 1'b0;
  logic       rst_n, ptr_rst, wr_en;
  logic [7:0] wr_data;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;
  logic       cmd_valid, crc_err, overflow_err, format_err;
  logic [6:0] cmd_len;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] blk [64];

  always #10 clk = ~clk;

  cmd_mailbox i_cmd_mailbox (
    .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_len(cmd_len), .crc_err(crc_err),
    .overflow_err(overflow_err), .format_err(format_err)
  );

  // {len, seed, mode, gap}; mode 0 good, 1 bad crc, 2 good+0xFF tail,
  // 3 good+stray tail, 4 bad count
  localparam logic [31:0] VEC [9] = '{
    {8'd3,  8'h11, 8'd0, 8'd0}, {8'd9,  8'h20, 8'd0, 8'd1},
    {8'd64, 8'h05, 8'd0, 8'd3}, {8'd12, 8'h7A, 8'd1, 8'd0},
    {8'd6,  8'h40, 8'd2, 8'd2}, {8'd7,  8'h33, 8'd3, 8'd0},
    {8'd2,  8'h50, 8'd4, 8'd0}, {8'd65, 8'h61, 8'd4, 8'd0},
    {8'd20, 8'hC3, 8'd0, 8'd2}
  };

  function automatic logic [15:0] crc16(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c ^= {blk[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic pre;
    ptr_rst = 1'b1; @(posedge clk); #2; ptr_rst = 1'b0;
  endtask

  task automatic build(input int len, input logic [7:0] seed, input logic bad);
    logic [15:0] c;
    blk[0] = 8'(len);
    for (int i = 1; i < len - 2; i++) blk[i] = seed ^ 8'(i * 37);
    c = crc16(len - 2);
    if (bad) c ^= 16'h0100;
    blk[len-2] = c[15:8]; blk[len-1] = c[7:0];
  endtask

  // writes block bytes 0..len-2, last byte left for caller
  task automatic send_head(input int len, input int gap);
    for (int i = 0; i < len - 1; i++) begin
      put(blk[i]);
      if (gap != 0 && (i % 4) == 3) idle(gap);
    end
  endtask

  initial begin
    int t0;
    t0 = 0;
    wait (t0 == 1);
  end

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ptr_rst = 1'b0; wr_en = 1'b0; wr_data = '0; rd_addr = '0;
    idle(3); #3 rst_n = 1'b1; idle(4);
    // R1
    chk("R1 valid", cmd_valid, 0); chk("R1 crc", crc_err, 0);
    chk("R1 ovf", overflow_err, 0); chk("R1 fmt", format_err, 0);

    foreach (VEC[v]) begin
      int len, mode, gap;
      logic [7:0] seed;
      len = VEC[v][31:24]; seed = VEC[v][23:16];
      mode = VEC[v][15:8]; gap = VEC[v][7:0];
      pre();
      if (mode == 4) begin
        // R9
        put(8'(len)); put(seed); put(seed);
        chk("R9 fmt", format_err, 1); chk("R9 no release", cmd_valid, 0);
        put(8'h00); idle(1);
        chk("R9 still no release", cmd_valid, 0);
      end else begin
        build(len, seed, mode == 1);
        send_head(len, gap);
        put(blk[len-1]);
        if (mode == 1) begin
          chk("R6 crc_err", crc_err, 1); chk("R6 no release", cmd_valid, 0);
        end else begin
          // R3 R4 R5
          chk("R4 R5 release", cmd_valid, 1); chk("R4 len", cmd_len, len);
          chk("R5 crc_err low", crc_err, 0);
          rd_addr = 6'(len - 1); #1 chk("R11 last byte", rd_data, blk[len-1]);
          rd_addr = 6'd0;        #1 chk("R11 count byte", rd_data, len);
          idle(1); chk("R4 single pulse", cmd_valid, 0);
          if (mode == 2) begin
            put(8'hFF); put(8'hFF); idle(1);
            // R7
            chk("R7 fmt", format_err, 0); chk("R7 len", cmd_len, len);
            rd_addr = 6'(len - 1); #1 chk("R7 stored byte", rd_data, blk[len-1]);
          end
          if (mode == 3) begin
            put(8'hFF); put(8'h3C);
            chk("R8 fmt", format_err, 1);
          end
        end
      end
    end

    // R6: retry without reset is ignored, then accepted after reset
    pre(); build(10, 8'h99, 1'b1); send_head(10, 0); put(blk[9]);
    chk("R6 err", crc_err, 1);
    build(10, 8'h99, 1'b0); send_head(10, 0); put(blk[9]);
    chk("R6 ignored", cmd_valid, 0); chk("R6 sticky", crc_err, 1);
    pre();
    chk("R2 cleared", crc_err, 0);
    send_head(10, 0); put(blk[9]);
    chk("R6 retry release", cmd_valid, 1);

    // R10
    pre(); build(64, 8'h0D, 1'b0); send_head(64, 0); put(blk[63]);
    chk("R10 release first", cmd_valid, 1);
    chk("R10 no ovf yet", overflow_err, 0);
    put(8'hFF);
    chk("R10 ovf", overflow_err, 1); chk("R10 fmt clean", format_err, 0);
    pre(); chk("R2 ovf cleared", overflow_err, 0);

    // R12: simultaneous strobe drops the byte
    pre(); build(3, 8'h00, 1'b0);
    ptr_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h07;
    @(posedge clk); #2; ptr_rst = 1'b0; wr_en = 1'b0;
    put(blk[0]); put(blk[1]); put(blk[2]);
    chk("R12 reset wins", cmd_valid, 1); chk("R12 len", cmd_len, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule